// File: doc/BRIEF.md
# I2C Auto-Sequencing Transfer Master

This block is an I2C master that runs one whole transfer on its own once the host has set it up. The host loads a target address and a transfer word that carries the byte count, the direction and a stop-after flag, then sets the run bit. The engine then needs no further help. It generates START and sends the address byte, and it checks the acknowledge. It moves the requested number of bytes between the bus and a transmit or receive byte FIFO, and optionally closes with STOP. When the transfer ends it reports one encoded outcome in a status word and raises a completion flag.

Timing at the bit level is not part of this block. The engine issues one bus symbol at a time (START, STOP, write one bit, read one bit) to an external bit-timing layer and waits for that layer's done strobe. The same strobe returns the sampled data line and an arbitration-lost indication.

A transfer without STOP leaves the engine holding the bus, still busy. The next transfer therefore opens with a repeated START, so a register-index write can run straight into a data read. A soft reset returns everything to idle.

Top module: `i2c_auto_master`

## Requirements
- R1: Host writes use `wr_sel` codes 0 = control (bit 31 soft reset), 1 = transfer word (length in bits [15:0], bit 16 read=1/write=0, bit 17 stop-after, bit 31 run), 2 = target address (field in bits [19:10]), 3 = TX byte push (bits [7:0]), 4 = interrupt status (bit 9 write-1-to-clear).
- R2: A run request with length of at least 1, accepted while idle or holding the bus, issues START and then the address byte. That byte is target address bits [6:0] followed by the direction bit (1 = read), sent MSB first. The engine then reads the acknowledge slot.
- R3: A write transfer pops one TX byte per data byte and sends it MSB first, each byte followed by an acknowledge slot. It succeeds once `length` bytes have been acknowledged.
- R4: A read transfer receives `length` bytes MSB first into the RX FIFO. The master drives ACK (0) after every byte except the last, which it answers with NACK (1).
- R5: `trans_status` bit 0 = success, bit 1 = aborted, bit 2 = data byte not acknowledged, bit 3 = no device (address not acknowledged), bit 4 = timeout, and bit 17 = busy. Exactly one of bits [4:0] is set after a transfer, and all of them clear when a new transfer starts.
- R6: A NACK on the address or on a data byte, or a timeout, makes the engine issue STOP and then report the error with busy low.
- R7: With stop-after set, STOP follows the last byte, busy stays high until STOP completes, and the outcome appears then. Without it, success is reported with busy still high and no STOP, and the next run request opens with a repeated START.
- R8: When a write byte is due with the TX FIFO empty, or a received byte cannot be stored because the RX FIFO is full, the engine waits. After `TMO_CYC` cycles it ends the transfer with the timeout outcome.
- R9: An arbitration-lost indication on a bit-layer done strobe ends the transfer at once with the aborted outcome, releasing the bus without STOP.
- R10: `irq_done` rises when a transfer ends and stays set until the host writes 1 to bit 9 of the interrupt status; writing 0 there leaves it set.
- R11: A run request with length 0 is ignored: no bus symbol, busy stays low, no completion flag.
- R12: `fifo_status` bits: [6:0] TX level, 7 TX full, 8 TX empty, [22:16] RX level, 23 RX full, 24 RX empty. A TX push into a full FIFO is dropped. `rx_data` shows the oldest RX byte and `rx_pop` removes it.
- R13: Reset or soft reset leaves the engine idle, both FIFOs empty, `trans_status` zero and `irq_done` low.
- R14: `bit_req` with `bit_cmd` (0 START, 1 STOP, 2 write bit, 3 read bit) and `bit_wval` stays steady until a `bit_done` strobe. `bit_rval` is sampled on that strobe for read symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Host register selector |
| wr_data | input | 32 | Host write data |
| rx_pop | input | 1 | Remove the oldest RX byte |
| rx_data | output | 8 | Oldest RX byte |
| trans_status | output | 32 | Outcome and busy word |
| fifo_status | output | 32 | FIFO levels and full/empty flags |
| irq_done | output | 1 | Completion flag |
| bit_req | output | 1 | Bus symbol request to bit layer |
| bit_cmd | output | 2 | Bus symbol kind |
| bit_wval | output | 1 | Bit value for a write symbol |
| bit_done | input | 1 | Bit layer finished the symbol |
| bit_rval | input | 1 | Sampled data line for a read symbol |
| bit_arb_lost | input | 1 | Arbitration lost during the symbol |

## Verification
Some properties hold on every cycle, and the assertions check them. The symbol request must hold steady until its done strobe. A finished transfer must carry exactly one outcome bit. Errors must end with the bus released, while a stop-less success must keep busy high. A zero-length run request must leave the engine idle, and a soft reset must clear status, flag and FIFOs in one cycle. Other behaviour shows only in the bench's scenarios against its own target model: the exact bytes and bit order on the bus, the ACK/NACK pattern on reads, the START and STOP counts in a chained write-then-read, the FIFO levels left behind by an error, and the timeout and arbitration outcomes.

// File: rtl/i2c_auto_pkg.sv
package i2c_auto_pkg;

    localparam int LEN_W       = 16;
    localparam int LVL_FIELD_W = 7;
    localparam int TADDR_W     = 10;

    localparam int AC_RD_BIT    = 16;
    localparam int AC_STOP_BIT  = 17;
    localparam int AC_RUN_BIT   = 31;
    localparam int CTL_SRST_BIT = 31;
    localparam int INT_DONE_BIT = 9;
    localparam int TADDR_LSB    = 10;

    typedef enum logic [2:0] {
        SEL_CTRL    = 3'd0,
        SEL_XFER    = 3'd1,
        SEL_TADDR   = 3'd2,
        SEL_TXBYTE  = 3'd3,
        SEL_INTSTAT = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bit_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_HOLD, S_START, S_SEND, S_GETACK,
        S_TXLOAD, S_RECV, S_RXSTORE, S_PUTACK, S_STOP
    } seq_state_e;

    typedef struct packed {
        logic timeout;
        logic no_dev;
        logic no_ack;
        logic abort;
        logic success;
    } outcome_t;

    localparam outcome_t OC_NONE  = 5'b00000;
    localparam outcome_t OC_OK    = 5'b00001;
    localparam outcome_t OC_ABORT = 5'b00010;
    localparam outcome_t OC_NOACK = 5'b00100;
    localparam outcome_t OC_NODEV = 5'b01000;
    localparam outcome_t OC_TMO   = 5'b10000;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             rd;
        logic             stop;
    } xfer_cfg_t;

    function automatic logic [31:0] pack_status(outcome_t oc, logic busy);
        return {14'd0, busy, 12'd0, oc};
    endfunction

    function automatic logic [31:0] pack_fifo(
        logic [LVL_FIELD_W-1:0] tx_lvl, logic tx_full, logic tx_empty,
        logic [LVL_FIELD_W-1:0] rx_lvl, logic rx_full, logic rx_empty);
        return {7'd0, rx_empty, rx_full, rx_lvl, 7'd0, tx_empty, tx_full, tx_lvl};
    endfunction

endpackage

// File: rtl/i2c_auto_fifo.sv
module i2c_auto_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign level   = cnt;
    assign dout    = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LVL_W'(1);
                2'b01:   cnt <= cnt - LVL_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/i2c_auto_seq.sv
module i2c_auto_seq
    import i2c_auto_pkg::*;
#(
    parameter int TMO_CYC = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                srst,
    input  logic                start,
    input  xfer_cfg_t           cfg,
    input  logic [TADDR_W-1:0]  tgt_addr,
    input  logic                tx_empty,
    input  logic [7:0]          tx_data,
    output logic                tx_pop,
    input  logic                rx_full,
    output logic                rx_push,
    output logic [7:0]          rx_byte,
    output logic                bit_req,
    output logic [1:0]          bit_cmd,
    output logic                bit_wval,
    input  logic                bit_done,
    input  logic                bit_rval,
    input  logic                bit_arb_lost,
    output logic                busy,
    output logic                done_pulse,
    output outcome_t            outcome
);
    localparam int TW = $clog2(TMO_CYC + 1);

    seq_state_e       state;
    outcome_t         pend;
    logic [LEN_W-1:0] cnt;
    logic             rd, stp, in_addr;
    logic [7:0]       shreg;
    logic [2:0]       bitcnt;
    logic [TW-1:0]    wait_cnt;
    logic             go, last_byte, tmo_hit;
    bit_cmd_e         cmd;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^tgt_addr[TADDR_W-1:7];
    assign busy      = (state != S_IDLE);
    assign go        = start && (cfg.len != '0) && (state == S_IDLE || state == S_HOLD);
    assign last_byte = (cnt == LEN_W'(1));
    assign tmo_hit   = (wait_cnt == TW'(TMO_CYC - 1));
    assign tx_pop    = (state == S_TXLOAD) && !tx_empty;
    assign rx_push   = (state == S_RXSTORE) && !rx_full;
    assign rx_byte   = shreg;

    always_comb begin
        bit_req  = 1'b1;
        cmd      = BC_READ;
        bit_wval = 1'b1;
        case (state)
            S_START:  cmd = BC_START;
            S_STOP:   cmd = BC_STOP;
            S_SEND:   begin cmd = BC_WRITE; bit_wval = shreg[7]; end
            S_PUTACK: begin cmd = BC_WRITE; bit_wval = last_byte; end
            S_GETACK, S_RECV: cmd = BC_READ;
            default:  bit_req = 1'b0;
        endcase
    end
    assign bit_cmd = cmd;

    always_ff @(posedge clk) begin
        done_pulse <= 1'b0;
        if (rst || srst) begin
            state    <= S_IDLE;
            outcome  <= OC_NONE;
            pend     <= OC_NONE;
            cnt      <= '0;
            rd       <= 1'b0;
            stp      <= 1'b0;
            in_addr  <= 1'b0;
            shreg    <= '0;
            bitcnt   <= '0;
            wait_cnt <= '0;
        end else if (bit_req && bit_done && bit_arb_lost) begin
            state      <= S_IDLE;
            outcome    <= OC_ABORT;
            done_pulse <= 1'b1;
        end else begin
            case (state)
                S_IDLE, S_HOLD: if (go) begin
                    state   <= S_START;
                    outcome <= OC_NONE;
                    pend    <= OC_NONE;
                    cnt     <= cfg.len;
                    rd      <= cfg.rd;
                    stp     <= cfg.stop;
                end
                S_START: if (bit_done) begin
                    shreg   <= {tgt_addr[6:0], rd};
                    bitcnt  <= '0;
                    in_addr <= 1'b1;
                    state   <= S_SEND;
                end
                S_SEND: if (bit_done) begin
                    shreg  <= {shreg[6:0], 1'b0};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) state <= S_GETACK;
                end
                S_GETACK: if (bit_done) begin
                    bitcnt <= '0;
                    if (bit_rval) begin
                        pend  <= in_addr ? OC_NODEV : OC_NOACK;
                        state <= S_STOP;
                    end else if (in_addr) begin
                        in_addr <= 1'b0;
                        state   <= rd ? S_RECV : S_TXLOAD;
                    end else if (last_byte) begin
                        if (stp) begin
                            pend  <= OC_OK;
                            state <= S_STOP;
                        end else begin
                            outcome    <= OC_OK;
                            done_pulse <= 1'b1;
                            state      <= S_HOLD;
                        end
                    end else begin
                        cnt   <= cnt - LEN_W'(1);
                        state <= S_TXLOAD;
                    end
                end
                S_TXLOAD: begin
                    if (!tx_empty) begin
                        shreg    <= tx_data;
                        bitcnt   <= '0;
                        wait_cnt <= '0;
                        state    <= S_SEND;
                    end else if (tmo_hit) begin
                        wait_cnt <= '0;
                        pend     <= OC_TMO;
                        state    <= S_STOP;
                    end else begin
                        wait_cnt <= wait_cnt + TW'(1);
                    end
                end
                S_RECV: if (bit_done) begin
                    shreg  <= {shreg[6:0], bit_rval};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) state <= S_RXSTORE;
                end
                S_RXSTORE: begin
                    if (!rx_full) begin
                        wait_cnt <= '0;
                        state    <= S_PUTACK;
                    end else if (tmo_hit) begin
                        wait_cnt <= '0;
                        pend     <= OC_TMO;
                        state    <= S_STOP;
                    end else begin
                        wait_cnt <= wait_cnt + TW'(1);
                    end
                end
                S_PUTACK: if (bit_done) begin
                    bitcnt <= '0;
                    if (last_byte) begin
                        if (stp) begin
                            pend  <= OC_OK;
                            state <= S_STOP;
                        end else begin
                            outcome    <= OC_OK;
                            done_pulse <= 1'b1;
                            state      <= S_HOLD;
                        end
                    end else begin
                        cnt   <= cnt - LEN_W'(1);
                        state <= S_RECV;
                    end
                end
                S_STOP: if (bit_done) begin
                    outcome    <= pend;
                    done_pulse <= 1'b1;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(bit_req) && !$past(bit_done) && !$past(srst)) |-> (bit_req && $stable(bit_cmd) && $stable(bit_wval))); // R14
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> $onehot(outcome)); // R5
    AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && (outcome.timeout || outcome.no_dev || outcome.no_ack || outcome.abort)) |-> !busy); // R6
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && outcome.success && !stp) |-> busy); // R7
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (start && cfg.len == '0 && !busy && !srst) |=> !busy); // R11

endmodule

// File: rtl/i2c_auto_master.sv
module i2c_auto_master
    import i2c_auto_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int TMO_CYC    = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rx_pop,
    output logic [7:0]  rx_data,
    output logic [31:0] trans_status,
    output logic [31:0] fifo_status,
    output logic        irq_done,
    output logic        bit_req,
    output logic [1:0]  bit_cmd,
    output logic        bit_wval,
    input  logic        bit_done,
    input  logic        bit_rval,
    input  logic        bit_arb_lost
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    reg_sel_e           sel;
    logic               soft_rst, run_req, tx_push, int_clr;
    xfer_cfg_t          cfg;
    logic [TADDR_W-1:0] tgt_addr;
    logic               tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
    logic [7:0]         tx_head, rx_byte;
    logic [LVL_W-1:0]   tx_lvl, rx_lvl;
    logic               busy, done_pulse;
    outcome_t           outcome;
    logic               unused_wdata;

    assign sel          = reg_sel_e'(wr_sel);
    assign soft_rst     = wr_en && (sel == SEL_CTRL)    && wr_data[CTL_SRST_BIT];
    assign run_req      = wr_en && (sel == SEL_XFER)    && wr_data[AC_RUN_BIT];
    assign tx_push      = wr_en && (sel == SEL_TXBYTE);
    assign int_clr      = wr_en && (sel == SEL_INTSTAT) && wr_data[INT_DONE_BIT];
    assign cfg          = '{len: wr_data[LEN_W-1:0], rd: wr_data[AC_RD_BIT], stop: wr_data[AC_STOP_BIT]};
    assign unused_wdata = ^wr_data[30:20];

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_addr <= '0;
        end else if (wr_en && sel == SEL_TADDR) begin
            tgt_addr <= wr_data[TADDR_LSB +: TADDR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)  irq_done <= 1'b0;
        else if (done_pulse)  irq_done <= 1'b1;
        else if (int_clr)     irq_done <= 1'b0;
    end

    i2c_auto_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(tx_push), .din(wr_data[7:0]), .pop(tx_pop), .dout(tx_head),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl)
    );

    i2c_auto_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_data),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl)
    );

    i2c_auto_seq #(.TMO_CYC(TMO_CYC)) u_seq (
        .clk(clk), .rst(rst), .srst(soft_rst), .start(run_req), .cfg(cfg),
        .tgt_addr(tgt_addr),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
        .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_wval(bit_wval),
        .bit_done(bit_done), .bit_rval(bit_rval), .bit_arb_lost(bit_arb_lost),
        .busy(busy), .done_pulse(done_pulse), .outcome(outcome)
    );

    assign trans_status = pack_status(outcome, busy);
    assign fifo_status  = pack_fifo(LVL_FIELD_W'(tx_lvl), tx_full, tx_empty,
                                    LVL_FIELD_W'(rx_lvl), rx_full, rx_empty);

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !soft_rst) |=> irq_done); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_done && !int_clr && !soft_rst) |=> irq_done); // R10
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (trans_status == 32'd0 && !irq_done && fifo_status == 32'h0100_0100)); // R13

endmodule

// File: tb/i2c_auto_master_bench.sv
module i2c_auto_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TMO        = 40;
    localparam int NVEC       = 7;
    // {rd, stop, len[3:0], nack_addr, nack_at[3:0], expected outcome[4:0]}
    localparam logic [NVEC-1:0][15:0] VECS = {
        {1'b1, 1'b1, 4'd2, 1'b1, 4'd0, 5'd8},
        {1'b0, 1'b1, 4'd8, 1'b0, 4'd0, 5'd1},
        {1'b1, 1'b1, 4'd1, 1'b0, 4'd0, 5'd1},
        {1'b0, 1'b1, 4'd4, 1'b0, 4'd2, 5'd4},
        {1'b0, 1'b1, 4'd1, 1'b1, 4'd0, 5'd8},
        {1'b1, 1'b1, 4'd4, 1'b0, 4'd0, 5'd1},
        {1'b0, 1'b1, 4'd3, 1'b0, 4'd0, 5'd1}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0, rx_pop = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rx_data;
    logic [31:0] trans_status, fifo_status;
    logic        irq_done, bit_req, bit_wval;
    logic [1:0]  bit_cmd;
    logic        bit_done = 1'b0, bit_rval = 1'b0, bit_arb_lost = 1'b0;

    int tests = 0, fails = 0;

    // target model state
    int         n_start, n_stop, n_resp, bitpos, byteidx, wr_cnt, ack_cnt, abort_at;
    logic       reading, nack_addr;
    int         nack_at;
    logic [7:0] sh, addr_seen;
    logic [7:0] wr_log [16];
    logic       ack_log [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_auto_master #(.FIFO_DEPTH(DEPTH), .TMO_CYC(TMO)) u_i2c_auto_master (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rx_pop(rx_pop), .rx_data(rx_data), .trans_status(trans_status),
        .fifo_status(fifo_status), .irq_done(irq_done),
        .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_wval(bit_wval),
        .bit_done(bit_done), .bit_rval(bit_rval), .bit_arb_lost(bit_arb_lost)
    );

    function automatic logic [7:0] tgt_byte(int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_start = 0; n_stop = 0; n_resp = 0; wr_cnt = 0; ack_cnt = 0;
        bitpos = 0; byteidx = 0; reading = 1'b0; sh = '0; addr_seen = '0;
        abort_at = 0; nack_addr = 1'b0; nack_at = 0;
    endtask

    // bit-layer and target model, driven away from the active edge
    initial begin
        int dly = 2;
        clear_logs();
        forever begin
            @(negedge clk);
            if (bit_done) begin
                bit_done = 1'b0; bit_arb_lost = 1'b0; dly = 2;
            end else if (!bit_req) begin
                dly = 2;
            end else if (dly != 0) begin
                dly--;
            end else begin
                n_resp++;
                if (abort_at != 0 && n_resp == abort_at) bit_arb_lost = 1'b1;
                case (bit_cmd)
                    2'd0: begin n_start++; bitpos = 0; byteidx = 0; reading = 1'b0; end
                    2'd1: n_stop++;
                    2'd2: begin
                        if (reading && bitpos == 8) begin
                            ack_log[ack_cnt] = bit_wval; ack_cnt++;
                            bitpos = 0; byteidx++;
                        end else begin
                            sh = {sh[6:0], bit_wval}; bitpos++;
                        end
                    end
                    default: begin
                        if (bitpos == 8) begin
                            if (byteidx == 0) begin
                                addr_seen = sh; reading = sh[0]; bit_rval = nack_addr;
                            end else begin
                                wr_log[wr_cnt] = sh; wr_cnt++;
                                bit_rval = (byteidx == nack_at);
                            end
                            bitpos = 0; byteidx++;
                        end else begin
                            logic [7:0] b;
                            b = tgt_byte(byteidx);
                            bit_rval = b[7 - bitpos]; bitpos++;
                        end
                    end
                endcase
                bit_done = 1'b1;
            end
        end
    end

    task automatic wreg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk);
        b = rx_data; rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic start_xfer(input logic rd, input logic stp, input int len, input logic [9:0] a);
        wreg(3'd2, {12'd0, a, 10'd0});
        wreg(3'd1, {1'b1, 13'd0, stp, rd, 16'(len)});
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq_done && n < 4000) begin @(negedge clk); n++; end
        chk({tag, " completion flag"}, {31'd0, irq_done}, 32'd1);
    endtask

    task automatic soft_reset();
        wreg(3'd0, 32'h8000_0000);
        clear_logs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 reset status", trans_status, 32'd0);
        chk("R13 reset fifo", fifo_status, 32'h0100_0100);
        chk("R13 reset flag", {31'd0, irq_done}, 32'd0);
        chk("R14 idle no request", {31'd0, bit_req}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic       v_rd, v_stp, v_na;
            int         v_len, v_nat, popped;
            logic [4:0] v_exp;
            logic [9:0] a;
            {v_rd, v_stp, v_len[3:0], v_na, v_nat[3:0], v_exp} = VECS[i];
            v_len = v_len & 15; v_nat = v_nat & 15;
            a = 10'h2C0 + 10'(i);
            soft_reset();
            nack_addr = v_na; nack_at = v_nat;
            if (!v_rd) for (int k = 0; k < v_len; k++) wreg(3'd3, 32'(8'h10 + 8'(i * 16 + k)));
            start_xfer(v_rd, v_stp, v_len, a);
            wait_irq("R10 vector");
            chk("R5 outcome", trans_status, {27'd0, v_exp});
            chk("R1 address byte", {24'd0, addr_seen}, {24'd0, a[6:0], v_rd});
            chk("R2 one start", n_start, 32'd1);
            chk(v_exp == 5'd1 ? "R7 stop issued" : "R6 stop on error", n_stop, 32'd1);
            if (!v_rd) begin
                popped = (v_exp == 5'd8) ? 0 : ((v_nat != 0) ? v_nat : v_len);
                chk("R12 tx level left", {25'd0, fifo_status[6:0]}, 32'(v_len - popped));
            end
            if (v_exp == 5'd1 && !v_rd) begin
                chk("R14 symbol count", n_resp, 32'(2 + 9 * (v_len + 1)));
                for (int k = 0; k < v_len; k++)
                    chk("R3 byte sent", {24'd0, wr_log[k]}, {24'd0, 8'h10 + 8'(i * 16 + k)});
            end
            if (v_exp == 5'd1 && v_rd) begin
                chk("R12 rx level", {25'd0, fifo_status[22:16]}, 32'(v_len));
                for (int k = 0; k < v_len; k++) begin
                    chk("R4 master ack", {31'd0, ack_log[k]}, (k == v_len - 1) ? 32'd1 : 32'd0);
                    pop_rx(b);
                    chk("R4 byte received", {24'd0, b}, {24'd0, tgt_byte(k + 1)});
                end
                chk("R12 rx empty", {31'd0, fifo_status[24]}, 32'd1);
            end
            if (v_exp == 5'd4) chk("R6 bytes before nack", wr_cnt, 32'(v_nat));
            wreg(3'd4, 32'h0000_0200);
        end

        // TX full handling and soft reset
        soft_reset();
        for (int k = 0; k < DEPTH + 1; k++) wreg(3'd3, 32'(k));
        chk("R12 tx full drops push", fifo_status, 32'h0100_0088);
        soft_reset();
        @(negedge clk);
        chk("R13 soft reset fifo", fifo_status, 32'h0100_0100);

        // zero length
        wreg(3'd1, 32'h8002_0000);
        repeat (20) @(negedge clk);
        chk("R11 zero length busy", trans_status, 32'd0);
        chk("R11 zero length flag", {31'd0, irq_done}, 32'd0);
        chk("R11 zero length bus", n_start, 32'd0);

        // TX empty timeout
        soft_reset();
        wreg(3'd3, 32'h55);
        start_xfer(1'b0, 1'b1, 2, 10'h033);
        wait_irq("R8 tx wait");
        chk("R8 tx timeout", trans_status, 32'h10);
        chk("R8 stop after timeout", n_stop, 32'd1);
        wreg(3'd4, 32'h200);

        // RX full timeout
        soft_reset();
        start_xfer(1'b1, 1'b1, DEPTH + 1, 10'h034);
        wait_irq("R8 rx wait");
        chk("R8 rx timeout", trans_status, 32'h10);
        chk("R8 rx full flag", {31'd0, fifo_status[23]}, 32'd1);

        // chained write without stop, then read
        soft_reset();
        wreg(3'd3, 32'h2A);
        start_xfer(1'b0, 1'b0, 1, 10'h048);
        wait_irq("R7 hold");
        chk("R7 success while busy", trans_status, 32'h0002_0001);
        chk("R7 no stop yet", n_stop, 32'd0);
        wreg(3'd4, 32'h0000_0000);
        chk("R10 write 0 keeps flag", {31'd0, irq_done}, 32'd1);
        wreg(3'd4, 32'h0000_0200);
        chk("R10 write 1 clears flag", {31'd0, irq_done}, 32'd0);
        start_xfer(1'b1, 1'b1, 2, 10'h048);
        @(negedge clk);
        chk("R5 outcome cleared on start", {27'd0, trans_status[4:0]}, 32'd0);
        wait_irq("R7 chained read");
        chk("R7 repeated start", n_start, 32'd2);
        chk("R7 single stop", n_stop, 32'd1);
        chk("R7 chained outcome", trans_status, 32'd1);
        chk("R3 register index", {24'd0, wr_log[0]}, 32'h2A);
        pop_rx(b);
        chk("R4 chained byte", {24'd0, b}, {24'd0, tgt_byte(1)});

        // arbitration lost
        soft_reset();
        wreg(3'd3, 32'h11);
        abort_at = 5;
        start_xfer(1'b0, 1'b1, 1, 10'h021);
        wait_irq("R9 abort");
        chk("R9 abort outcome", trans_status, 32'h2);
        chk("R9 no stop", n_stop, 32'd0);
        soft_reset();
        @(negedge clk);
        chk("R13 soft reset flag", {31'd0, irq_done}, 32'd0);
        chk("R13 soft reset status", trans_status, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule